// File: doc/BRIEF.md
# Falling-Edge External Interrupt Controller

This block watches a small set of external pins and turns each high-to-low transition into a latched request flag. A flag is set whether or not its source is enabled. The per-source enable bits and one global enable only decide whether the processor core is asked to jump to the shared interrupt vector. All sources share that fixed vector, so the service routine reads the flag register to find out which pin fired. It then clears the flag itself with a bit-clear write.

Software reaches the flags, the per-source enables and the global enable through one register port. Each write either sets or clears the bits picked by a mask. When the core enters the vector it raises an acknowledge. The controller then drops the global enable, so no nested entry can happen. The global enable comes back when the core reports return-from-interrupt. Each pin passes through a synchroniser before its edge is detected, so the pins can be asynchronous to the clock.

Top module: `extint_ctrl`

## Requirements
- R1: A source flag is set by a high-to-low transition of its pin, and by nothing else in hardware. A low-to-high transition neither sets nor clears a flag.
- R2: A detected edge sets the flag even when that source's enable bit is 0.
- R3: `irq_o` is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable bit at 1.
- R4: With the global enable at 0, `irq_o` stays 0 whatever the flags and enables hold.
- R5: `vector_o` always presents address 8, the one entry point shared by every source.
- R6: Vector acknowledge and return-from-interrupt leave the flags unchanged. A flag goes to 0 only through a bit-clear write to the flag register (selector 0, operation 0, mask bit of that source at 1).
- R7: If a bit-clear write to a flag meets a new edge of the same source in the same cycle, the flag ends at 1.
- R8: `vec_ack_i` sets the global enable to 0 on the next edge. `reti_i` without `vec_ack_i` sets it back to 1. Acknowledge takes priority over return, and return takes priority over a software write.
- R9: Each source has its own flag and its own enable bit. An edge on one pin never changes another source's flag, and source i sits in bit i of the flag and enable registers.
- R10: Synchronous active-high reset sets all flags, enables and the global enable to 0, so `irq_o` is 0.
- R11: The register selector `reg_sel_i` picks what `reg_rdata_o` shows: 0 gives the flags, 1 gives the enables, 2 gives the global enable in bit 0 with the other bits 0, and 3 gives all zeros. `reg_op_i` = 1 sets the masked bits and 0 clears them. For the global enable, only mask bit 0 counts.
- R12: A pin that falls and stays low shows its flag at 1 by the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | NUM_SRC | Asynchronous external interrupt pins, idle high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register selector for both write and read |
| reg_op_i | input | 1 | 1 = set masked bits, 0 = clear masked bits |
| reg_mask_i | input | NUM_SRC | Bit mask for the write |
| reg_rdata_o | output | NUM_SRC | Contents of the selected register |
| irq_o | output | 1 | Request to enter the interrupt vector |
| vector_o | output | VEC_W | Shared vector address |
| vec_ack_i | input | 1 | Core has entered the vector |
| reti_i | input | 1 | Core returns from interrupt |

## Verification
The main sweep goes through every combination of the four enable settings, both global-enable settings and all four falling-pin patterns. This tells apart a flag that latches regardless of its enable from one gated by it, a request gated by the global enable from one that is not, and a pin steering its own bit from one that crosses over to its neighbour. After each pattern the pins rise again, to show that a rising edge leaves the flags alone. Targeted sequences then place a bit-clear write in exactly the cycle an edge is detected. They also run an acknowledge followed by a return, to separate the flags (untouched by either) from the global enable (dropped by one and restored by the other).

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

    // Register selector encoding, shared by write and read paths
    typedef enum logic [1:0] {
        SEL_FLAG   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_GLOBAL = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_SET   = 1'b1
    } reg_op_e;

    // One decoded register command
    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        reg_op_e  op;
    } reg_cmd_t;

    // Next value of one bit under a masked set/clear write
    function automatic logic apply_bit(logic cur, reg_op_e op, logic hit);
        if (!hit) return cur;
        return (op == OP_SET);
    endfunction

    // True when a command targets the given register
    function automatic logic cmd_hits(reg_cmd_t cmd, reg_sel_e which);
        return cmd.wr && (cmd.sel == which);
    endfunction

endpackage

// File: rtl/extint_edge.sv
`timescale 1ns/1ps
module extint_edge #(
    parameter int NUM_SRC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pin_i,
    output logic [NUM_SRC-1:0] fall_o
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic [SYNC_STAGES-1:0] chain_q;
        logic                   last_q;

        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i[s]};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= pin_i[s];
                end
            end
        end

        // Previous synchronised level, reset to the idle-high state
        always_ff @(posedge clk) begin
            if (rst) begin
                last_q <= 1'b1;
            end else begin
                last_q <= chain_q[SYNC_STAGES-1];
            end
        end

        assign fall_o[s] = last_q & ~chain_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/extint_flags.sv
`timescale 1ns/1ps
module extint_flags
    import extint_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fall_i,
    input  reg_cmd_t           cmd_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] flag_o,
    output logic [NUM_SRC-1:0] en_o
);

    logic hit_flag;
    logic hit_en;

    assign hit_flag = cmd_hits(cmd_i, SEL_FLAG);
    assign hit_en   = cmd_hits(cmd_i, SEL_ENABLE);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
        logic flag_q;
        logic en_q;
        logic flag_sw;
        logic en_sw;

        assign flag_sw = apply_bit(flag_q, cmd_i.op, hit_flag && mask_i[s]);
        assign en_sw   = apply_bit(en_q,   cmd_i.op, hit_en   && mask_i[s]);

        // A fresh edge outranks a software clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
                en_q   <= 1'b0;
            end else begin
                flag_q <= fall_i[s] ? 1'b1 : flag_sw;
                en_q   <= en_sw;
            end
        end

        assign flag_o[s] = flag_q;
        assign en_o[s]   = en_q;
    end

endmodule

// File: rtl/extint_gate.sv
`timescale 1ns/1ps
module extint_gate
    import extint_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_cmd_t           cmd_i,
    input  logic               mask0_i,
    input  logic               ack_i,
    input  logic               ret_i,
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               gie_o,
    output logic               irq_o
);

    logic gie_q;
    logic pending;

    // Priority: vector entry, then return, then software
    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else if (ack_i) begin
            gie_q <= 1'b0;
        end else if (ret_i) begin
            gie_q <= 1'b1;
        end else begin
            gie_q <= apply_bit(gie_q, cmd_i.op, cmd_hits(cmd_i, SEL_GLOBAL) && mask0_i);
        end
    end

    assign pending = |(flag_i & en_i);
    assign gie_o   = gie_q;
    assign irq_o   = gie_q & pending;

endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_SRC     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8,
    parameter int VECTOR_ADDR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ext_pin_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_sel_i,
    input  logic               reg_op_i,
    input  logic [NUM_SRC-1:0] reg_mask_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vector_o,
    input  logic               vec_ack_i,
    input  logic               reti_i
);

    reg_cmd_t           cmd;
    logic [NUM_SRC-1:0] fall_w;
    logic [NUM_SRC-1:0] flag_w;
    logic [NUM_SRC-1:0] en_w;
    logic               gie_w;

    assign cmd.wr  = reg_wr_i;
    assign cmd.sel = reg_sel_e'(reg_sel_i);
    assign cmd.op  = reg_op_e'(reg_op_i);

    extint_edge #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_pin_i),
        .fall_o (fall_w)
    );

    extint_flags #(
        .NUM_SRC (NUM_SRC)
    ) u_flags (
        .clk    (clk),
        .rst    (rst),
        .fall_i (fall_w),
        .cmd_i  (cmd),
        .mask_i (reg_mask_i),
        .flag_o (flag_w),
        .en_o   (en_w)
    );

    extint_gate #(
        .NUM_SRC (NUM_SRC)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .mask0_i (reg_mask_i[0]),
        .ack_i   (vec_ack_i),
        .ret_i   (reti_i),
        .flag_i  (flag_w),
        .en_i    (en_w),
        .gie_o   (gie_w),
        .irq_o   (irq_o)
    );

    always_comb begin
        case (cmd.sel)
            SEL_FLAG:   reg_rdata_o = flag_w;
            SEL_ENABLE: reg_rdata_o = en_w;
            SEL_GLOBAL: reg_rdata_o = NUM_SRC'(gie_w);
            default:    reg_rdata_o = '0;
        endcase
    end

    assign vector_o = VEC_W'(VECTOR_ADDR);

endmodule

// File: rtl/extint_ctrl_chk.sv
`timescale 1ns/1ps
module extint_ctrl_chk #(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] fall,
    input logic [NUM_SRC-1:0] flag,
    input logic [NUM_SRC-1:0] en,
    input logic               gie,
    input logic               irq,
    input logic               reg_wr,
    input logic [1:0]         reg_sel,
    input logic               reg_op,
    input logic               vec_ack,
    input logic               reti
);

    // R1: a flag only rises after an edge or a software set to the flag register
    a_r1_flag_cause: assert property (@(posedge clk) disable iff (rst)
        (|(flag & ~$past(flag))) |->
            $past((fall != '0) || (reg_wr && reg_sel == 2'd0 && reg_op)));

    // R6: without a bit-clear to the flag register no flag falls
    a_r6_no_silent_clear: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_sel == 2'd0 && !reg_op) |=> ((flag & $past(flag)) == $past(flag)));

    // R7: every detected edge leaves its flag at 1
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (fall != '0) |=> ((flag & $past(fall)) == $past(fall)));

    // R3: a request always has an enabled, flagged source behind it
    a_r3_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(flag & en)));

    // R4: no request while the global enable is off
    a_r4_irq_needs_global: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

    // R8: vector entry drops the global enable
    a_r8_ack_drops_global: assert property (@(posedge clk) disable iff (rst)
        vec_ack |=> !gie);

    // R8: return restores the global enable
    a_r8_reti_restores: assert property (@(posedge clk) disable iff (rst)
        (reti && !vec_ack) |=> gie);

    // R10: reset leaves everything cleared
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (flag == '0 && en == '0 && !gie && !irq));

endmodule

bind extint_ctrl extint_ctrl_chk #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fall    (fall_w),
    .flag    (flag_w),
    .en      (en_w),
    .gie     (gie_w),
    .irq     (irq_o),
    .reg_wr  (reg_wr_i),
    .reg_sel (reg_sel_i),
    .reg_op  (reg_op_i),
    .vec_ack (vec_ack_i),
    .reti    (reti_i)
);

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb;

    localparam int NS = 2;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] pins = '1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic          reg_op = 1'b0;
    logic [NS-1:0] reg_mask = '0;
    logic [NS-1:0] rdata;
    logic          irq;
    logic [VW-1:0] vec;
    logic          ack = 1'b0;
    logic          reti = 1'b0;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    extint_ctrl #(
        .NUM_SRC     (NS),
        .SYNC_STAGES (2),
        .VEC_W       (VW),
        .VECTOR_ADDR (8)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ext_pin_i   (pins),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_op_i    (reg_op),
        .reg_mask_i  (reg_mask),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .vector_o    (vec),
        .vec_ack_i   (ack),
        .reti_i      (reti)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic op, input logic [NS-1:0] mask);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_op = op; reg_mask = mask;
        @(negedge clk);
        reg_wr = 1'b0; reg_mask = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [NS-1:0] val);
        reg_sel = sel;
        #1;
        val = rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] v;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R10: reset state
        rd(2'd0, v); chk("R10 flags after reset", v, 0);
        rd(2'd1, v); chk("R10 enables after reset", v, 0);
        rd(2'd2, v); chk("R10 global after reset", v, 0);
        chk("R10 irq after reset", irq, 0);
        chk("R5 vector address", vec, 8);

        // R1 R2 R3 R4 R9: sweep enables x global x falling pattern
        for (int en = 0; en < 4; en++) begin
            for (int g = 0; g < 2; g++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    pins = '1;
                    idle(4);
                    wr(2'd0, 1'b0, '1);
                    wr(2'd1, 1'b0, '1);
                    wr(2'd1, 1'b1, NS'(en));
                    wr(2'd2, g[0], 2'b01);
                    pins = ~NS'(pat);
                    idle(5);
                    rd(2'd0, v);
                    chk("R2/R9 flags follow falling pins", v, pat);
                    chk("R3/R4 irq from flags, enables, global", irq,
                        (g != 0 && (pat & en) != 0) ? 1 : 0);
                    pins = '1;
                    idle(5);
                    rd(2'd0, v);
                    chk("R1 rising edge leaves flags", v, pat);
                end
            end
        end

        // R1: rising edge after a clear does not set a flag
        pins = '0;
        idle(5);
        wr(2'd0, 1'b0, '1);
        pins = '1;
        idle(5);
        rd(2'd0, v); chk("R1 rise from low sets nothing", v, 0);

        // R12: latency of the synchroniser and detector
        @(negedge clk); pins = 2'b10;
        idle(2);
        rd(2'd0, v); chk("R12 not yet visible after two edges", v, 0);
        idle(1);
        rd(2'd0, v); chk("R12 visible after third edge", v, 1);
        pins = '1;
        idle(4);

        // R6 R8: acknowledge and return
        wr(2'd0, 1'b0, '1);
        wr(2'd1, 1'b1, 2'b01);
        wr(2'd2, 1'b1, 2'b01);
        pins = 2'b10;
        idle(5);
        chk("R3 irq raised", irq, 1);
        pulse_ack();
        chk("R8 irq drops after ack", irq, 0);
        rd(2'd2, v); chk("R8 global cleared by ack", v, 0);
        rd(2'd0, v); chk("R6 ack keeps flag", v, 1);
        pulse_reti();
        rd(2'd2, v); chk("R8 global restored by reti", v, 1);
        rd(2'd0, v); chk("R6 reti keeps flag", v, 1);
        chk("R8 irq back after reti", irq, 1);
        wr(2'd0, 1'b0, 2'b01);
        rd(2'd0, v); chk("R6 software clear", v, 0);
        chk("R6 irq gone after clear", irq, 0);

        // R8: ack and reti together, ack wins
        @(negedge clk); ack = 1'b1; reti = 1'b1;
        @(negedge clk); ack = 1'b0; reti = 1'b0;
        rd(2'd2, v); chk("R8 ack outranks reti", v, 0);
        pins = '1;
        idle(4);

        // R7: clear in the same cycle as a detected edge
        wr(2'd0, 1'b1, 2'b01);
        @(negedge clk); pins = 2'b10;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd0; reg_op = 1'b0; reg_mask = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; reg_mask = '0;
        rd(2'd0, v); chk("R7 edge wins over clear", v, 1);
        wr(2'd0, 1'b0, 2'b01);
        rd(2'd0, v); chk("R7 later clear still works", v, 0);
        pins = '1;
        idle(4);

        // R11: read selector
        wr(2'd1, 1'b1, 2'b11);
        wr(2'd2, 1'b1, 2'b11);
        rd(2'd1, v); chk("R11 enable readback", v, 3);
        rd(2'd2, v); chk("R11 global only in bit 0", v, 1);
        rd(2'd3, v); chk("R11 selector 3 reads zero", v, 0);
        wr(2'd2, 1'b0, 2'b10);
        rd(2'd2, v); chk("R11 global ignores mask bit 1", v, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule